// File: doc/BRIEF.md
# Two-Wire Bus Slave with 16-Bit Register Words

This block sits behind a two-wire serial bus (clock and data lines) and lets a bus master reach a bank of 16-bit registers through byte-wide transfers. The lines are oversampled with the system clock. The block answers only to its fixed 7-bit device address. The first byte of a write sets a register pointer. Every following pair of bytes forms one register word, sent high byte first.

A read starts with a write header that sets the pointer. The master then issues a repeated start with the read direction bit. The block returns words high byte first and keeps going until the master declines a byte. After each complete word the pointer moves to the next register. The register side is a plain parallel port. It has an address, a 16-bit write value with a one-cycle strobe, and a 16-bit read value that the register bank returns combinationally for the address shown.

Top module: `twi_word_slave`

## Requirements
- R1: The block acknowledges (holds SDA low through the acknowledge clock) an address byte whose upper seven bits are 1011100, bit 0 giving direction (0 write, 1 read). Any other address gets no acknowledge, and the block ignores every later byte until the next start or stop.
- R2: A start is SDA falling while SCL is high. A stop is SDA rising while SCL is high. A stop returns the block to idle with SDA released.
- R3: In a write, the first byte after the address is loaded as the 8-bit register pointer and is acknowledged.
- R4: Write data bytes are each acknowledged. The first byte of a pair is held back. After the second byte, one single-cycle strobe writes {first, second} to the pointer address.
- R5: After each written word the pointer increments, so consecutive words land in consecutive registers.
- R6: After a pointer write, a repeated start and the read address, the block sends the word at the pointer as two bytes, high byte first, MSB first within each byte.
- R7: During reads the pointer increments after each word. The whole word is captured when its high byte is loaded, so a change of the read value during the low byte is not seen.
- R8: A no-acknowledge from the master after a read byte ends the read, and SDA is released.
- R9: Writing a new pointer resets the byte pairing, so a held, unpaired high byte is discarded.
- R10: After reset SDA is released and no write strobe is issued.
- R11: The block changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock, much faster than SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Bus clock line |
| sda_i | input | 1 | Bus data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr_o | output | 8 | Register address (write address while strobing, else pointer) |
| reg_wdata_o | output | 16 | Register write value |
| reg_we_o | output | 1 | Single-cycle register write strobe |
| reg_rdata_i | input | 16 | Register read value for reg_addr_o |

## Verification
Checked on every cycle: the SDA drive stays steady while SCL is high, the drive drops after a stop, after a declined read byte and after a foreign address, the strobe lasts one cycle, and the pointer has stepped past each strobed address. Only the bench scenarios can show the byte order of words in both directions, the acknowledge values, the discarded unpaired byte after a pointer rewrite, the word capture at the high byte, and that foreign traffic writes nothing.

// File: rtl/twi_pkg.sv
package twi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_RX_ACK,
    ST_TX,
    ST_TX_ACK
  } twi_state_e;

  typedef enum logic [1:0] {
    K_ADDR,
    K_PTR,
    K_DATA
  } twi_kind_e;
endpackage

// File: rtl/twi_sync.sv
module twi_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '1;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/twi_cond.sv
module twi_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_i,
  input  logic sda_i,
  output logic start_o,
  output logic stop_o,
  output logic scl_rise_o,
  output logic scl_fall_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
    end
  end

  assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
  assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;
  assign scl_rise_o = scl_i & ~scl_q;
  assign scl_fall_o = ~scl_i & scl_q;
endmodule

// File: rtl/twi_word_port.sv
module twi_word_port #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_ptr_i,
  input  logic [AW-1:0] ptr_i,
  input  logic          wr_byte_i,
  input  logic [7:0]    byte_i,
  input  logic          rd_byte_i,
  input  logic          rd_first_i,
  output logic [7:0]    tx_byte_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int HW = DW / 2;

  logic [AW-1:0] ptr_q, waddr_q;
  logic [HW-1:0] stage_q;
  logic [DW-1:0] word_q, wdata_q;
  logic          upper_q, we_q;
  logic          upper_sel;

  assign upper_sel = rd_first_i | upper_q;
  assign tx_byte_o = upper_sel ? reg_rdata_i[DW-1:HW] : word_q[HW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      waddr_q <= '0;
      stage_q <= '0;
      word_q  <= '0;
      wdata_q <= '0;
      upper_q <= 1'b1;
      we_q    <= 1'b0;
    end else begin
      we_q <= 1'b0;
      if (load_ptr_i) begin
        ptr_q   <= ptr_i;
        upper_q <= 1'b1;
      end else if (wr_byte_i) begin
        if (upper_q) begin
          stage_q <= byte_i;
          upper_q <= 1'b0;
        end else begin
          we_q    <= 1'b1;
          waddr_q <= ptr_q;
          wdata_q <= {stage_q, byte_i};
          ptr_q   <= ptr_q + AW'(1);
          upper_q <= 1'b1;
        end
      end else if (rd_byte_i) begin
        if (upper_sel) begin
          word_q  <= reg_rdata_i;
          upper_q <= 1'b0;
        end else begin
          ptr_q   <= ptr_q + AW'(1);
          upper_q <= 1'b1;
        end
      end
    end
  end

  assign reg_we_o    = we_q;
  assign reg_wdata_o = wdata_q;
  assign reg_addr_o  = we_q ? waddr_q : ptr_q;

  AST_WE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o); // R4
  AST_PTR_AFTER_WORD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (ptr_q == reg_addr_o + AW'(1))); // R5
endmodule

// File: rtl/twi_word_slave.sv
module twi_word_slave
  import twi_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b1011100,
  parameter int         SYNC_STAGES = 2,
  parameter int         AW          = 8,
  parameter int         DW          = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_we_o,
  input  logic [DW-1:0] reg_rdata_i
);
  localparam int BITS = 8;
  localparam int CW   = $clog2(BITS + 1);

  logic [1:0] sync_q;
  logic       scl_s, sda_s;
  logic       start_det, stop_det, scl_rise, scl_fall;

  twi_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({scl_i, sda_i}),
    .q_o   (sync_q)
  );
  assign scl_s = sync_q[1];
  assign sda_s = sync_q[0];

  twi_cond u_cond (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .scl_i     (scl_s),
    .sda_i     (sda_s),
    .start_o   (start_det),
    .stop_o    (stop_det),
    .scl_rise_o(scl_rise),
    .scl_fall_o(scl_fall)
  );

  twi_state_e      state_q;
  twi_kind_e       kind_q;
  logic [CW-1:0]   cnt_q;
  logic [BITS-1:0] rx_q, tx_q;
  logic            rw_q, ack_q;

  logic       byte_done, load_ptr, wr_byte, rd_first, rd_byte;
  logic [7:0] tx_byte;

  assign byte_done = (state_q == ST_RX) && scl_fall && (cnt_q == CW'(BITS));
  assign load_ptr  = byte_done && (kind_q == K_PTR);
  assign wr_byte   = byte_done && (kind_q == K_DATA);
  assign rd_first  = (state_q == ST_RX_ACK) && scl_fall && (kind_q == K_ADDR) && rw_q;
  assign rd_byte   = rd_first || ((state_q == ST_TX_ACK) && scl_fall && ack_q);

  twi_word_port #(.AW(AW), .DW(DW)) u_port (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_ptr_i (load_ptr),
    .ptr_i      (rx_q[AW-1:0]),
    .wr_byte_i  (wr_byte),
    .byte_i     (rx_q),
    .rd_byte_i  (rd_byte),
    .rd_first_i (rd_first),
    .tx_byte_o  (tx_byte),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_rdata_i(reg_rdata_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
      rx_q    <= '0;
      tx_q    <= '1;
      rw_q    <= 1'b0;
      ack_q   <= 1'b0;
    end else if (start_det) begin
      state_q <= ST_RX;
      kind_q  <= K_ADDR;
      cnt_q   <= '0;
    end else if (stop_det) begin
      state_q <= ST_IDLE;
    end else begin
      unique case (state_q)
        ST_RX: begin
          if (scl_rise) begin
            rx_q  <= {rx_q[BITS-2:0], sda_s};
            cnt_q <= cnt_q + CW'(1);
          end else if (byte_done) begin
            cnt_q <= '0;
            if (kind_q == K_ADDR) begin
              if (rx_q[7:1] == DEV_ADDR) begin
                rw_q    <= rx_q[0];
                state_q <= ST_RX_ACK;
              end else begin
                state_q <= ST_IDLE;
              end
            end else begin
              state_q <= ST_RX_ACK;
            end
          end
        end
        ST_RX_ACK: begin
          if (scl_fall) begin
            cnt_q <= '0;
            if (rd_first) begin
              tx_q    <= tx_byte;
              state_q <= ST_TX;
            end else begin
              kind_q  <= (kind_q == K_ADDR) ? K_PTR : K_DATA;
              state_q <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (scl_fall) begin
            if (cnt_q == CW'(BITS - 1)) begin
              cnt_q   <= '0;
              state_q <= ST_TX_ACK;
            end else begin
              tx_q  <= {tx_q[BITS-2:0], 1'b1};
              cnt_q <= cnt_q + CW'(1);
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            ack_q <= ~sda_s;
          end else if (scl_fall) begin
            if (ack_q) begin
              tx_q    <= tx_byte;
              state_q <= ST_TX;
            end else begin
              state_q <= ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign sda_oe_o = (state_q == ST_RX_ACK) || ((state_q == ST_TX) && !tx_q[BITS-1]);

  AST_OE_STEADY_SCL_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_s && $past(scl_s)) |-> $stable(sda_oe_o)); // R11
  AST_STOP_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_det |=> !sda_oe_o); // R2
  AST_NACK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_q == ST_TX_ACK) && scl_fall && !ack_q && !start_det && !stop_det) |=> !sda_oe_o); // R8
  AST_FOREIGN_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_done && (kind_q == K_ADDR) && (rx_q[7:1] != DEV_ADDR)) |=> !sda_oe_o); // R1
endmodule

// File: tb/tb_twi_word_slave.sv
module tb_twi_word_slave;
  localparam int Q = 8;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        scl_m = 1'b1;
  logic        sda_m = 1'b1;
  logic        sda_line;
  logic        sda_oe_o;
  logic [7:0]  reg_addr_o;
  logic [15:0] reg_wdata_o;
  logic        reg_we_o;
  logic [15:0] reg_rdata_i;
  logic [15:0] mem [256];

  int checks = 0;
  int failures = 0;
  int oe_glitches = 0;
  bit done = 1'b0;
  logic [23:0] exp_q[$];

  always #5 clk = ~clk;

  assign sda_line    = sda_m & ~sda_oe_o;
  assign reg_rdata_i = mem[reg_addr_o];

  twi_word_slave dut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .scl_i      (scl_m),
    .sda_i      (sda_line),
    .sda_oe_o   (sda_oe_o),
    .reg_addr_o (reg_addr_o),
    .reg_wdata_o(reg_wdata_o),
    .reg_we_o   (reg_we_o),
    .reg_rdata_i(reg_rdata_i)
  );

  task automatic check(input bit ok, input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
  endtask

  // Monitor: pops expected writes as strobes appear; R4 R5 R11
  logic prev_scl = 1'b1, prev_oe = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (scl_m && prev_scl && (sda_oe_o != prev_oe)) oe_glitches++;
      prev_scl <= scl_m;
      prev_oe  <= sda_oe_o;
      if (reg_we_o) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R4 unexpected strobe", {reg_addr_o, reg_wdata_o}, 24'h0);
        end else begin
          logic [23:0] e;
          e = exp_q.pop_front();
          check({reg_addr_o, reg_wdata_o} == e, "R4/R5 write", {reg_addr_o, reg_wdata_o}, e);
        end
        mem[reg_addr_o] = reg_wdata_o;
      end
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack_bit);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack_bit = sda_line; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit give_ack);
    sda_m = 1'b1;
    b = '0;
    for (int i = 0; i < 8; i++) begin
      wq(Q);
      scl_m = 1'b1; wq(Q);
      b = {b[6:0], sda_line}; wq(Q);
      scl_m = 1'b0;
    end
    wq(Q);
    sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
    scl_m = 1'b1; wq(2 * Q);
    scl_m = 1'b0; wq(Q);
    sda_m = 1'b1;
  endtask

  task automatic send_chk(input logic [7:0] b, input logic exp_ack, input string req);
    logic a;
    send_byte(b, a);
    check(a == exp_ack, req, {23'h0, a}, {23'h0, exp_ack});
  endtask

  task automatic recv_chk(input logic [7:0] exp, input bit give_ack, input string req);
    logic [7:0] b;
    recv_byte(b, give_ack);
    check(b == exp, req, {16'h0, b}, {16'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    mem[8'h30] = 16'hCAFE;
    wq(5);
    #1;
    check(sda_oe_o == 1'b0, "R10 sda released", {23'h0, sda_oe_o}, 24'h0);
    check(reg_we_o == 1'b0, "R10 no strobe", {23'h0, reg_we_o}, 24'h0);
    rst_ni = 1'b1;
    wq(10);

    // R1 R3 R4 R5: two words from pointer 0x04
    exp_q.push_back({8'h04, 16'h1234});
    exp_q.push_back({8'h05, 16'h5678});
    bus_start();
    send_chk(8'hB8, 1'b0, "R1 write address ack");
    send_chk(8'h04, 1'b0, "R3 pointer ack");
    send_chk(8'h12, 1'b0, "R4 data ack");
    send_chk(8'h34, 1'b0, "R4 data ack");
    send_chk(8'h56, 1'b0, "R4 data ack");
    send_chk(8'h78, 1'b0, "R4 data ack");
    bus_stop();
    wq(Q);
    check(sda_line == 1'b1 && sda_oe_o == 1'b0, "R2 released after stop", {23'h0, sda_oe_o}, 24'h0);

    // R9: unpaired byte dropped by new pointer
    exp_q.push_back({8'h20, 16'h9ABC});
    bus_start();
    send_chk(8'hB8, 1'b0, "R1 write address ack");
    send_chk(8'h10, 1'b0, "R3 pointer ack");
    send_chk(8'hAA, 1'b0, "R4 data ack");
    bus_start();
    send_chk(8'hB8, 1'b0, "R2 repeated start address ack");
    send_chk(8'h20, 1'b0, "R9 pointer ack");
    send_chk(8'h9A, 1'b0, "R9 data ack");
    send_chk(8'hBC, 1'b0, "R9 data ack");
    bus_stop();
    wq(Q);
    check(mem[8'h10] == 16'h0, "R9 no write at old pointer", {8'h10, mem[8'h10]}, {8'h10, 16'h0});

    // R6 R7 R8: read two words from 0x04
    bus_start();
    send_chk(8'hB8, 1'b0, "R6 write address ack");
    send_chk(8'h04, 1'b0, "R6 pointer ack");
    bus_start();
    send_chk(8'hB9, 1'b0, "R1 read address ack");
    recv_chk(8'h12, 1'b1, "R6 read high byte");
    recv_chk(8'h34, 1'b1, "R6 read low byte");
    recv_chk(8'h56, 1'b1, "R7 next word high");
    recv_chk(8'h78, 1'b0, "R7 next word low");
    wq(2);
    check(sda_oe_o == 1'b0, "R8 released after nack", {23'h0, sda_oe_o}, 24'h0);
    wq(2 * Q);
    check(sda_oe_o == 1'b0, "R8 stays released", {23'h0, sda_oe_o}, 24'h0);
    bus_stop();

    // R7: word captured at high byte
    bus_start();
    send_chk(8'hB8, 1'b0, "R7 write address ack");
    send_chk(8'h30, 1'b0, "R7 pointer ack");
    bus_start();
    send_chk(8'hB9, 1'b0, "R7 read address ack");
    recv_chk(8'hCA, 1'b1, "R7 high byte");
    mem[8'h30] = 16'h0000;
    recv_chk(8'hFE, 1'b0, "R7 low byte from captured word");
    bus_stop();

    // R1: foreign address ignored
    bus_start();
    send_chk(8'hA0, 1'b1, "R1 foreign address nack");
    send_chk(8'h55, 1'b1, "R1 later byte ignored");
    send_chk(8'h66, 1'b1, "R1 later byte ignored");
    bus_stop();
    bus_start();
    send_chk(8'hB9 ^ 8'h02, 1'b1, "R1 near address nack");
    bus_stop();
    wq(4 * Q);

    check(exp_q.size() == 0, "R4 all expected writes seen", exp_q.size(), 24'h0);
    check(oe_glitches == 0, "R11 drive steady while SCL high", oe_glitches, 24'h0);
    check(mem[8'h05] == 16'h5678, "R5 second word at next register", {8'h05, mem[8'h05]}, {8'h05, 16'h5678});

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule